// File: doc/BRIEF.md
# Bidirectional Scan Line Driver Logic

This block is the digital core of a cascadable row-scan driver for a display panel. A serial shift register holds one bit per row and can move data either way. A strobe-controlled latch copies the register into a parallel stage. Blanking and polarity gating then turn each latched bit into a row-control output. Several copies can be chained: the serial output at one end of a device feeds the serial input of the next device.

The block runs on a fast system clock. The shift clock input is sampled, and each rising edge causes exactly one shift. Each serial end is split into a data input, a data output and an output-enable, so that a pad wrapper can build a true bidirectional pin from it. The direction input decides which end receives data and which end drives data out.

The clear input is asynchronous and empties the register. Because the zeros pass through a transparent latch and then through the polarity gating, clear can force every row output high or low. A parameter selects how the latch is built: a level-sensitive latch, or a flop array on the system clock that is enabled while the strobe is low.

Top module: `scan_row_driver`

## Requirements
- R1: After the synchronous active-low reset, the register and the latch hold all zeros. With blank and polarity low, every row output therefore reads 0.
- R2: With dir high, each rising edge of shift_clk moves register bit i into bit i+1 and loads end_a_in into bit 0. After N_ROWS shifts, the first bit entered appears on end_b_out.
- R3: With dir low, each rising edge of shift_clk moves register bit i+1 into bit i and loads end_b_in into bit N_ROWS-1. After N_ROWS shifts, the first bit entered appears on end_a_out.
- R4: With dir high, end_a_oe is 0, end_b_oe is 1 and end_b_out drives register bit N_ROWS-1. With dir low, end_a_oe is 1, end_b_oe is 0 and end_a_out drives register bit 0.
- R5: A shift_clk held at a constant level, at either level, causes no shift. The register and both serial outputs stay steady, and holding shift_clk high for many system clocks causes only one shift.
- R6: A high level on clr empties the register at once. While clr is high, shift edges leave the register empty.
- R7: While strobe is low, the latch follows the register.
- R8: While strobe is high, the latch keeps its value, even if the register shifts.
- R9: While blank is high, every row output equals pol, whatever the data, clear and strobe inputs are.
- R10: While blank is low, row output n is latch bit n when pol is low, and the inverse of latch bit n when pol is high.
- R11: With clr high, strobe low and blank low, every row output equals pol.
- R12: LATCH_LEVEL=1 gives a transparent latch, so the outputs follow a shift in the same system cycle. LATCH_LEVEL=0 gives a flop stage that follows one system cycle later. Apart from this lag, both variants behave the same at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Shift clock; each rising edge gives one shift |
| clr | input | 1 | Asynchronous register clear, active high |
| strobe | input | 1 | Latch control: transparent when low, hold when high |
| blank | input | 1 | When high, forces all row outputs to the pol level |
| pol | input | 1 | Output polarity; when high, inverts the latched data |
| dir | input | 1 | Shift direction: 1 = end A to end B, 0 = end B to end A |
| end_a_in | input | 1 | Serial data in at end A |
| end_a_out | output | 1 | Serial data out at end A (register bit 0) |
| end_a_oe | output | 1 | Output-enable for end A |
| end_b_in | input | 1 | Serial data in at end B |
| end_b_out | output | 1 | Serial data out at end B (register bit N_ROWS-1) |
| end_b_oe | output | 1 | Output-enable for end B |
| row_out | output | N_ROWS | Row-control outputs after gating |

## Verification
Both latch variants are built side by side with 16 rows and driven in lockstep. Several bit sequences, computed by formula, are shifted through the register in each direction. After every shift the whole output vector and the far serial end are compared with a bench model, which separates a wrong shift direction, a wrong entry end and an off-by-one chain length. A shift clock held high for many cycles shows that a level does not count as an edge. A strobe-high window during shifting separates hold from transparency. A sweep over blank and polarity, with data in place and again under clear, separates the forced levels from inverted data. A single-cycle sample just after a shift shows the one-cycle lag of the flop variant against the transparent latch.

// File: rtl/scan_pkg.sv
// Shared types for the scan row driver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package scan_pkg;

    // Shift direction as seen on the dir input.
    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } scan_dir_e;

    // Latch build variants selected by the top-level parameter.
    localparam bit LATCH_FLOP  = 1'b0;
    localparam bit LATCH_LEVEL = 1'b1;

endpackage

// File: rtl/scan_clk_edge.sv
// Detects rising edges of the shift clock on the system clock.
// Assumes: shift_clk is already synchronous to clk, or is driven away from
// the clk edge, and each phase of it lasts at least one clk period.
module scan_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    output logic shift_pulse
);

    logic sclk_q;

    // Keep the previous shift clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= shift_clk;
    end

    // A pulse for the one cycle in which the new level is high and the old one was low.
    always_comb shift_pulse = shift_clk & ~sclk_q;

    // R5: one edge yields exactly one pulse, even if the level stays high.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);

endmodule

// File: rtl/scan_shift_reg.sv
// Bidirectional serial shift register with asynchronous clear.
// Assumes: N >= 2; dir is stable in the cycle in which shift_pulse is high.
module scan_shift_reg #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_pulse,
    input  logic         dir,
    input  logic         a_in,
    input  logic         b_in,
    output logic [N-1:0] sr
);
    import scan_pkg::*;

    localparam int LAST = N - 1;

    logic [N-1:0] sr_nxt;

    // Next value of each bit: take the neighbour on the upstream side.
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_first
            always_comb from_low = a_in;
        end else begin : g_mid_low
            always_comb from_low = sr[i-1];
        end
        if (i == LAST) begin : g_last
            always_comb from_high = b_in;
        end else begin : g_mid_high
            always_comb from_high = sr[i+1];
        end
        // Pick the source bit by shift direction.
        always_comb sr_nxt[i] = (scan_dir_e'(dir) == DIR_A_TO_B) ? from_low : from_high;
    end

    // Register update: clear wins at any time, then reset, then shift.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)              sr <= '0;
        else if (!rst_n)      sr <= '0;
        else if (shift_pulse) sr <= sr_nxt;
    end

    // R6: the register reads empty whenever clr is high.
    a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (sr == '0));

    // R2: end A feeds bit 0, and the rest moves up by one.
    a_r2_fwd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && dir && !clr) |=> (clr || (sr[0] == $past(a_in))));
    a_r2_fwd_move: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && dir && !clr) |=> (clr || (sr[LAST:1] == $past(sr[LAST-1:0]))));

    // R3: end B feeds the top bit, and the rest moves down by one.
    a_r3_rev_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && !dir && !clr) |=> (clr || (sr[LAST] == $past(b_in))));
    a_r3_rev_move: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && !dir && !clr) |=> (clr || (sr[LAST-1:0] == $past(sr[LAST:1]))));

    // R5: without an edge the contents stay steady.
    a_r5_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_pulse && !clr) |=> (clr || $stable(sr)));

endmodule

// File: rtl/scan_latch_stage.sv
// Parallel latch between the shift register and the output gating.
// LEVEL=1: a level-sensitive latch, open while strobe is low.
// LEVEL=0: a flop array on clk, loaded while strobe is low.
// Assumes: in the flop variant, strobe is synchronous to clk.
module scan_latch_stage #(
    parameter int N     = 64,
    parameter bit LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    import scan_pkg::*;

    if (LEVEL == LATCH_LEVEL) begin : g_level
        // Transparent while the strobe is low; holds while it is high.
        always_latch begin
            if (!strobe) q = d;
        end

        // R7: an open latch shows its input.
        a_r7_open_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe |-> (q == d));
    end else begin : g_flop
        // Load on each clock while the strobe is low; hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (!strobe) q <= d;
        end

        // R7: the flop stage copies its input one cycle later.
        a_r7_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe |=> (q == $past(d)));
        // R8: a high strobe freezes the stage.
        a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            strobe |=> $stable(q));
    end

endmodule

// File: rtl/scan_out_gate.sv
// Blanking and polarity gating of each latched row bit.
// Assumes: purely combinational; blank takes priority over the data.
module scan_out_gate #(
    parameter int N = 64
) (
    input  logic [N-1:0] lat_q,
    input  logic         blank,
    input  logic         pol,
    output logic [N-1:0] row_out
);

    for (genvar i = 0; i < N; i++) begin : g_row
        // Blank forces the polarity level; otherwise pol inverts the data.
        always_comb row_out[i] = blank ? pol : (lat_q[i] ^ pol);
    end

endmodule

// File: rtl/scan_row_driver.sv
// Top level of the scan row driver logic: edge detection, shift register,
// latch stage, output gating and the two split serial ends.
// Assumes: all inputs except clr are synchronous to clk.
module scan_row_driver #(
    parameter int N_ROWS      = 64,
    parameter bit LATCH_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic              clr,
    input  logic              strobe,
    input  logic              blank,
    input  logic              pol,
    input  logic              dir,
    input  logic              end_a_in,
    output logic              end_a_out,
    output logic              end_a_oe,
    input  logic              end_b_in,
    output logic              end_b_out,
    output logic              end_b_oe,
    output logic [N_ROWS-1:0] row_out
);
    import scan_pkg::*;

    localparam int LAST = N_ROWS - 1;

    logic              shift_pulse;
    logic [N_ROWS-1:0] sr;
    logic [N_ROWS-1:0] lat_q;

    scan_clk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_clk   (shift_clk),
        .shift_pulse (shift_pulse)
    );

    scan_shift_reg #(.N(N_ROWS)) u_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .shift_pulse (shift_pulse),
        .dir         (dir),
        .a_in        (end_a_in),
        .b_in        (end_b_in),
        .sr          (sr)
    );

    scan_latch_stage #(.N(N_ROWS), .LEVEL(LATCH_LEVEL)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .d      (sr),
        .q      (lat_q)
    );

    scan_out_gate #(.N(N_ROWS)) u_gate (
        .lat_q   (lat_q),
        .blank   (blank),
        .pol     (pol),
        .row_out (row_out)
    );

    // Serial ends: both carry their end bit, and only the downstream end is enabled.
    always_comb begin
        end_a_out = sr[0];
        end_b_out = sr[LAST];
        end_a_oe  = (scan_dir_e'(dir) == DIR_B_TO_A);
        end_b_oe  = (scan_dir_e'(dir) == DIR_A_TO_B);
    end

    // R9: blanking forces every row to the polarity level.
    a_r9_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (row_out == {N_ROWS{pol}}));

    // R10: without blanking, the rows carry the latch contents, inverted by pol.
    a_r10_data_path: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> ((row_out ^ {N_ROWS{pol}}) == lat_q));

    // R4: exactly one serial end is enabled as an output.
    a_r4_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({end_a_oe, end_b_oe}) == 1);

endmodule

// File: tb/scan_row_driver_bench.sv
// Self-checking bench: both latch variants run in lockstep against a bench model.
module scan_row_driver_bench;

    localparam int NR = 16;

    logic clk = 1'b0;
    logic rst_n, shift_clk, clr, strobe, blank, pol, dir, a_in, b_in;
    logic          f_a_out, f_a_oe, f_b_out, f_b_oe;
    logic          l_a_out, l_a_oe, l_b_out, l_b_oe;
    logic [NR-1:0] f_row, l_row;

    int total = 0;
    int bad   = 0;
    logic [NR-1:0] model;

    always #2 clk = ~clk;

    scan_row_driver #(.N_ROWS(NR), .LATCH_LEVEL(1'b0)) u_scan_row_driver (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .clr(clr),
        .strobe(strobe), .blank(blank), .pol(pol), .dir(dir),
        .end_a_in(a_in), .end_a_out(f_a_out), .end_a_oe(f_a_oe),
        .end_b_in(b_in), .end_b_out(f_b_out), .end_b_oe(f_b_oe),
        .row_out(f_row)
    );

    scan_row_driver #(.N_ROWS(NR), .LATCH_LEVEL(1'b1)) u_scan_row_driver_lvl (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .clr(clr),
        .strobe(strobe), .blank(blank), .pol(pol), .dir(dir),
        .end_a_in(a_in), .end_a_out(l_a_out), .end_a_oe(l_a_oe),
        .end_b_in(b_in), .end_b_out(l_b_out), .end_b_oe(l_b_oe),
        .row_out(l_row)
    );

    task automatic chk(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Row outputs of both variants against one expected vector.
    task automatic chk_rows(input string tag, input logic [NR-1:0] exp);
        chk({tag, " flop"}, f_row, exp);
        chk({tag, " level"}, l_row, exp);
    endtask

    // Bit value taken from the sequence formula.
    function automatic logic seq_bit(input int k, input int seed);
        return logic'(((k * k + 3 * k + seed) >> 1) & 1);
    endfunction

    // One shift-clock pulse; both variants settle by the final negedge.
    task automatic pulse_shift(input logic bit_in);
        a_in = bit_in;
        b_in = bit_in;
        shift_clk = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        @(negedge clk);
        if (dir) model = {model[NR-2:0], bit_in};
        else     model = {bit_in, model[NR-1:1]};
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NR-1:0] snap;
        rst_n = 1'b0; shift_clk = 1'b0; clr = 1'b0; strobe = 1'b0;
        blank = 1'b0; pol = 1'b0; dir = 1'b1; a_in = 1'b0; b_in = 1'b0;
        model = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_rows("R1 reset rows", '0);
        chk("R1 reset end_b_out", {{(NR-1){1'b0}}, f_b_out}, '0);

        // R2 / R7 / R4: forward sweeps with several sequences
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < NR + 3; k++) begin
                pulse_shift(seq_bit(k, s * 5 + 1));
                chk_rows("R2 R7 fwd rows", model);
                chk("R2 fwd end_b_out", {{(NR-1){1'b0}}, f_b_out}, {{(NR-1){1'b0}}, model[NR-1]});
                chk("R2 fwd end_b_out level", {{(NR-1){1'b0}}, l_b_out}, {{(NR-1){1'b0}}, model[NR-1]});
            end
        end
        chk("R4 fwd oe", {{(NR-2){1'b0}}, f_a_oe, f_b_oe}, {{(NR-2){1'b0}}, 2'b01});
        chk("R4 fwd oe level", {{(NR-2){1'b0}}, l_a_oe, l_b_oe}, {{(NR-2){1'b0}}, 2'b01});

        // R5: a level held high for many cycles gives a single shift
        a_in = ~model[0];
        shift_clk = 1'b1;
        repeat (8) @(negedge clk);
        model = {model[NR-2:0], a_in};
        chk_rows("R5 held high one shift", model);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk_rows("R5 held low no shift", model);

        // R3 / R4: reverse sweeps
        dir = 1'b0;
        @(negedge clk);
        chk("R4 rev oe", {{(NR-2){1'b0}}, f_a_oe, f_b_oe}, {{(NR-2){1'b0}}, 2'b10});
        chk("R4 rev oe level", {{(NR-2){1'b0}}, l_a_oe, l_b_oe}, {{(NR-2){1'b0}}, 2'b10});
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < NR + 2; k++) begin
                pulse_shift(seq_bit(k, s * 3 + 2));
                chk_rows("R3 rev rows", model);
                chk("R3 rev end_a_out", {{(NR-1){1'b0}}, f_a_out}, {{(NR-1){1'b0}}, model[0]});
                chk("R3 rev end_a_out level", {{(NR-1){1'b0}}, l_a_out}, {{(NR-1){1'b0}}, model[0]});
            end
        end

        // R8: hold while the register keeps shifting
        dir = 1'b1;
        strobe = 1'b1;
        @(negedge clk);
        snap = model;
        for (int k = 0; k < 5; k++) pulse_shift(~model[NR-1]);
        chk_rows("R8 hold", snap);
        strobe = 1'b0;
        repeat (2) @(negedge clk);
        chk_rows("R7 reopen", model);

        // R12: transparent variant follows at once, flop variant one cycle later
        snap = model;
        a_in = ~model[NR-1];
        shift_clk = 1'b1;
        @(negedge clk);
        model = {model[NR-2:0], a_in};
        chk("R12 level same cycle", l_row, model);
        chk("R12 flop lags", f_row, snap);
        shift_clk = 1'b0;
        @(negedge clk);
        chk("R12 flop catches up", f_row, model);

        // R9 / R10: blank and polarity sweep with data present
        for (int g = 0; g < 4; g++) begin
            blank = g[1];
            pol   = g[0];
            @(negedge clk);
            if (blank) chk_rows("R9 blank level", {NR{pol}});
            else       chk_rows("R10 data gate", model ^ {NR{pol}});
        end

        // R9: blank wins with strobe high too
        strobe = 1'b1; blank = 1'b1; pol = 1'b1;
        @(negedge clk);
        chk_rows("R9 blank with strobe", {NR{1'b1}});
        strobe = 1'b0; blank = 1'b0; pol = 1'b0;
        @(negedge clk);

        // R6 / R11: clear empties the register and forces the rows to pol
        clr = 1'b1;
        @(negedge clk);
        model = '0;
        for (int p = 0; p < 2; p++) begin
            pol = p[0];
            @(negedge clk);
            chk_rows("R11 clear rows", {NR{pol}});
        end
        pol = 1'b0;
        pulse_shift(1'b1);
        model = '0;
        chk_rows("R6 shift under clear", '0);
        chk("R6 end_b_out under clear", {{(NR-1){1'b0}}, f_b_out}, '0);
        blank = 1'b1; pol = 1'b1;
        @(negedge clk);
        chk_rows("R9 blank under clear", {NR{1'b1}});
        clr = 1'b0; blank = 1'b0; pol = 1'b0;
        @(negedge clk);
        pulse_shift(1'b1);
        chk_rows("R6 shift after clear", model);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule